// File: doc/BRIEF.md
# MMU Control Register Write Unit

This block keeps the control registers of a paged memory management unit and carries out privileged moves to and from them. It has a user root pointer and a supervisor root pointer (64 bits each), a translation control register (32 bits), two transparent translation registers (32 bits each) and a status register (16 bits). A requester presents one access per clock: a register select, a direction, the write data, the current privilege state and a flush-disable flag. The block stores the value and drives the side effects. These are a one-cycle pulse to flush the translation cache, a configuration-error pulse for an unusable value, and a privilege-violation pulse for an access from user state. Each transparent translation register's enable state is also driven as a level.

An access is sampled at a rising edge. The edge that samples a granted write also stores the value. The edge that samples a granted read loads the read bus. The same edge moves a small sequencer to the state that names what it just accepted. That state drives the flush and privilege outputs during the following cycle. The sequencer states are `ST_IDLE`, `ST_READ`, `ST_WR_FLUSH`, `ST_WR_QUIET` and `ST_DENY`. Every edge picks the next state from the sampled request, and the old state plays no part in that choice. No valid request leads to `ST_IDLE`. A valid request in user state leads to `ST_DENY`. A supervisor read leads to `ST_READ`. A supervisor write to a flushing register with flush-disable low leads to `ST_WR_FLUSH`. Any other supervisor write leads to `ST_WR_QUIET`. A separate two-stage chain carries a failed validity check forward, so the configuration error shows one cycle after the stored value is visible.

The register select codes are 0 for the user root pointer, 1 for the supervisor root pointer, 2 for translation control, 3 and 4 for the two transparent translation registers, and 5 for the status register. Codes 6 and 7 are unmapped.

Top module: `mmu_ctl_regs`

## Requirements
- R1: While reset is asserted and after it is released, every register reads as zero, and `flush_pulse`, `cfg_err`, `priv_viol`, `tt_en` and `rd_data` are low.
- R2: A granted write stores all 64 bits for a root pointer, bits [31:0] for translation control and both transparent translation registers, and bits [15:0] for the status register. A granted read zero-extends the selected register onto `rd_data`, which is valid in the cycle after the sampling edge.
- R3: A granted write to select 0, 1, 2, 3 or 4 with `req_nofl` low raises `flush_pulse` for exactly the cycle after the sampling edge.
- R4: A write with `req_nofl` high never raises `flush_pulse`.
- R5: A write to the status register (select 5) never raises `flush_pulse`, whatever `req_nofl` is.
- R6: A root pointer write whose descriptor-type bits [33:32] are 00 still stores the value. `cfg_err` then pulses one cycle after the cycle in which the stored value first becomes visible.
- R7: A translation control write with enable bit 31 set is checked. The page size [23:20] must be at least 8. The initial shift [19:16] plus the page size plus the index fields [15:12], [11:8], [7:4], [3:0], taken in that order up to the first zero field, must sum to exactly 32. On failure the value is stored unchanged and `cfg_err` pulses with the timing of R6.
- R8: When the R7 check passes, the value is stored with bit 31 cleared and no error is raised. A translation control write with bit 31 clear is stored unchanged with no check and no error.
- R9: `tt_en[i]` equals bit 15 of the last value written to transparent translation register i. It changes only on a granted write to that register.
- R10: An access with `req_super` low changes no register and leaves `rd_data` unchanged. It raises `priv_viol` for the following cycle, with no flush and no error.
- R11: A read has no side effects: no flush, no error and no register change. `rd_data` changes only on a granted read.
- R12: A write to select 6 or 7 changes nothing and raises no flush. A read of select 6 or 7 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | An access is presented this cycle |
| req_write | input | 1 | 1 = move to register, 0 = move from register |
| req_sel | input | 3 | Register select code |
| req_wdata | input | 64 | Write value, low bits used for narrow registers |
| req_super | input | 1 | Requester is in supervisor state |
| req_nofl | input | 1 | Suppress the cache flush for this write |
| rd_data | output | 64 | Zero-extended read value, registered |
| flush_pulse | output | 1 | One-cycle translation cache flush request |
| cfg_err | output | 1 | One-cycle configuration error, after the store |
| priv_viol | output | 1 | One-cycle privilege violation |
| tt_en | output | 2 | Enable state of each transparent translation register |

## Verification
The configuration error of a write lags its store by one cycle. So that error can land in the same cycle as the flush or privilege pulse of the next access. The bench provokes this with back-to-back accesses, both in a directed pair and by issuing a random access on every clock. It judges each output against its own access: the flush and privilege pulses are matched to the access sampled at the most recent edge, and `cfg_err` to the one sampled an edge earlier. A design that merges or misaligns the two paths is therefore caught.

// File: rtl/mmu_ctl_pkg.sv
package mmu_ctl_pkg;

    // bus and register widths
    localparam int DATA_W = 64;
    localparam int RP_W   = 64;
    localparam int TC_W   = 32;
    localparam int TT_W   = 32;
    localparam int SR_W   = 16;

    // register select map
    localparam int SEL_W  = 3;
    localparam int NUM_TT = 2;
    localparam logic [SEL_W-1:0] SEL_URP     = 3'd0;
    localparam logic [SEL_W-1:0] SEL_SRP     = 3'd1;
    localparam logic [SEL_W-1:0] SEL_TC      = 3'd2;
    localparam logic [SEL_W-1:0] SEL_TT_BASE = 3'd3;
    localparam logic [SEL_W-1:0] SEL_SR      = SEL_W'(int'(SEL_TT_BASE) + NUM_TT);

    // field positions the checks decode
    localparam int RP_DT_LSB     = 32;
    localparam int RP_DT_W       = 2;
    localparam int TC_E_BIT      = 31;
    localparam int TC_PS_LSB     = 20;
    localparam int TC_IS_LSB     = 16;
    localparam int TC_FLD_W      = 4;
    localparam int TC_NUM_TI     = 4;
    localparam int TC_TI_TOP_LSB = 12;
    localparam int TT_E_BIT      = 15;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WR_FLUSH,
        ST_WR_QUIET,
        ST_DENY
    } op_state_e;

endpackage

// File: rtl/mmu_root_chk.sv
module mmu_root_chk
    import mmu_ctl_pkg::*;
(
    input  logic [RP_W-1:0] value,
    output logic            bad
);

    logic [RP_DT_W-1:0] dtype;

    // a descriptor type of zero marks an unusable root descriptor
    always_comb begin
        dtype = value[RP_DT_LSB +: RP_DT_W];
        bad   = (dtype == '0);
    end

endmodule

// File: rtl/mmu_tc_chk.sv
module mmu_tc_chk
    import mmu_ctl_pkg::*;
#(
    parameter int PS_MIN  = 8,
    parameter int VA_BITS = 32
) (
    input  logic [TC_W-1:0] value,
    output logic            check_on,
    output logic            fields_ok
);

    localparam int FLD_MAX = (1 << TC_FLD_W) - 1;
    localparam int SUM_W   = $clog2((TC_NUM_TI + 2) * FLD_MAX + 1);

    logic [TC_FLD_W-1:0] ps;
    logic [TC_FLD_W-1:0] ishift;
    logic [TC_FLD_W-1:0] ti;
    logic [SUM_W-1:0]    total;
    logic                open;

    always_comb begin
        ps     = value[TC_PS_LSB +: TC_FLD_W];
        ishift = value[TC_IS_LSB +: TC_FLD_W];
        total  = SUM_W'(ps) + SUM_W'(ishift);
        open   = 1'b1;
        ti     = '0;
        // index fields count from the top one down to the first zero width
        for (int i = 0; i < TC_NUM_TI; i++) begin
            ti = value[TC_TI_TOP_LSB - i*TC_FLD_W +: TC_FLD_W];
            if (ti == '0) begin
                open = 1'b0;
            end
            if (open) begin
                total = total + SUM_W'(ti);
            end
        end
        check_on  = value[TC_E_BIT];
        fields_ok = (ps >= TC_FLD_W'(PS_MIN)) && (total == SUM_W'(VA_BITS));
    end

endmodule

// File: rtl/mmu_reg_bank.sv
module mmu_reg_bank
    import mmu_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tc_clear_e,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_TT-1:0] tt_en
);

    logic [RP_W-1:0]               urp_q;
    logic [RP_W-1:0]               srp_q;
    logic [TC_W-1:0]               tc_q;
    logic [TC_W-1:0]               tc_next;
    logic [SR_W-1:0]               sr_q;
    logic [NUM_TT-1:0][TT_W-1:0]   tt_view;
    logic [DATA_W-1:0]             rd_mux;
    logic [DATA_W-1:0]             rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            urp_q <= '0;
            srp_q <= '0;
        end else if (wr_en) begin
            if (sel == SEL_URP) urp_q <= wdata[RP_W-1:0];
            if (sel == SEL_SRP) srp_q <= wdata[RP_W-1:0];
        end
    end

    // a passed consistency check stores the value with its enable bit clear
    always_comb begin
        tc_next = wdata[TC_W-1:0];
        if (tc_clear_e) begin
            tc_next[TC_E_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc_q <= '0;
            sr_q <= '0;
        end else if (wr_en) begin
            if (sel == SEL_TC) tc_q <= tc_next;
            if (sel == SEL_SR) sr_q <= wdata[SR_W-1:0];
        end
    end

    for (genvar g = 0; g < NUM_TT; g++) begin : g_tt
        localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(int'(SEL_TT_BASE) + g);
        logic [TT_W-1:0] tt_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tt_q <= '0;
            end else if (wr_en && (sel == MY_SEL)) begin
                tt_q <= wdata[TT_W-1:0];
            end
        end

        assign tt_view[g] = tt_q;
        assign tt_en[g]   = tt_q[TT_E_BIT];

        // the enable level moves only on a write aimed at this register
        assert_tt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(wr_en && (sel == MY_SEL)) |-> $stable(tt_en[g]));
    end

    always_comb begin
        rd_mux = '0;
        if (sel == SEL_URP) rd_mux = DATA_W'(urp_q);
        if (sel == SEL_SRP) rd_mux = DATA_W'(srp_q);
        if (sel == SEL_TC)  rd_mux = DATA_W'(tc_q);
        if (sel == SEL_SR)  rd_mux = DATA_W'(sr_q);
        for (int i = 0; i < NUM_TT; i++) begin
            if (sel == SEL_W'(int'(SEL_TT_BASE) + i)) rd_mux = DATA_W'(tt_view[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= rd_mux;
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/mmu_ctl_seq.sv
module mmu_ctl_seq
    import mmu_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    input  logic req_super,
    input  logic req_nofl,
    input  logic sel_flushes,
    input  logic err_in,
    output logic grant_wr,
    output logic grant_rd,
    output logic flush_pulse,
    output logic priv_viol,
    output logic cfg_err
);

    op_state_e state_q;
    op_state_e state_d;
    logic      err_arm_q;
    logic      err_out_q;

    assign grant_wr = req_valid && req_super && req_write;
    assign grant_rd = req_valid && req_super && !req_write;

    // each edge records what it accepted; the old state plays no part
    always_comb begin
        if (!req_valid)                  state_d = ST_IDLE;
        else if (!req_super)             state_d = ST_DENY;
        else if (!req_write)             state_d = ST_READ;
        else if (sel_flushes && !req_nofl) state_d = ST_WR_FLUSH;
        else                             state_d = ST_WR_QUIET;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        flush_pulse = 1'b0;
        priv_viol   = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_READ:     ;
            ST_WR_FLUSH: flush_pulse = 1'b1;
            ST_WR_QUIET: ;
            ST_DENY:     priv_viol = 1'b1;
        endcase
    end

    // error arms with the store, reports one edge later
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_arm_q <= 1'b0;
            err_out_q <= 1'b0;
        end else begin
            err_arm_q <= grant_wr && err_in;
            err_out_q <= err_arm_q;
        end
    end

    assign cfg_err = err_out_q;

    assert_no_flush_when_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_nofl) |-> !flush_pulse);

    assert_priv_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_super) |-> (priv_viol && !flush_pulse));

    // R11: a read never produces a flush
    assert_read_no_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_write) |-> !flush_pulse);

endmodule

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs
    import mmu_ctl_pkg::*;
#(
    parameter int PS_MIN  = 8,
    parameter int VA_BITS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_super,
    input  logic              req_nofl,
    output logic [DATA_W-1:0] rd_data,
    output logic              flush_pulse,
    output logic              cfg_err,
    output logic              priv_viol,
    output logic [NUM_TT-1:0] tt_en
);

    logic sel_is_root;
    logic sel_is_tc;
    logic sel_is_tt;
    logic sel_flushes;
    logic root_bad;
    logic tc_check_on;
    logic tc_ok;
    logic err_in;
    logic tc_clear_e;
    logic grant_wr;
    logic grant_rd;

    assign sel_is_root = (req_sel == SEL_URP) || (req_sel == SEL_SRP);
    assign sel_is_tc   = (req_sel == SEL_TC);
    assign sel_is_tt   = (req_sel >= SEL_TT_BASE) && (req_sel < SEL_SR);
    assign sel_flushes = sel_is_root || sel_is_tc || sel_is_tt;

    mmu_root_chk u_root_chk (
        .value (req_wdata[RP_W-1:0]),
        .bad   (root_bad)
    );

    mmu_tc_chk #(
        .PS_MIN  (PS_MIN),
        .VA_BITS (VA_BITS)
    ) u_tc_chk (
        .value     (req_wdata[TC_W-1:0]),
        .check_on  (tc_check_on),
        .fields_ok (tc_ok)
    );

    assign err_in     = (sel_is_root && root_bad) || (sel_is_tc && tc_check_on && !tc_ok);
    assign tc_clear_e = sel_is_tc && tc_check_on && tc_ok;

    mmu_ctl_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_super   (req_super),
        .req_nofl    (req_nofl),
        .sel_flushes (sel_flushes),
        .err_in      (err_in),
        .grant_wr    (grant_wr),
        .grant_rd    (grant_rd),
        .flush_pulse (flush_pulse),
        .priv_viol   (priv_viol),
        .cfg_err     (cfg_err)
    );

    mmu_reg_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (grant_wr),
        .rd_en      (grant_rd),
        .sel        (req_sel),
        .wdata      (req_wdata),
        .tc_clear_e (tc_clear_e),
        .rd_data    (rd_data),
        .tt_en      (tt_en)
    );

    assert_status_no_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_write && req_sel == SEL_SR) |-> !flush_pulse);

    // R6/R7: an error only ever follows a granted write two edges back
    assert_err_after_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> $past(req_valid && req_write && req_super, 2));

    assert_unmapped_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_sel > SEL_SR) |-> !flush_pulse);

endmodule

// File: tb/mmu_ctl_regs_bench.sv
module mmu_ctl_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_sel = '0;
    logic [63:0] req_wdata = '0;
    logic        req_super = 1'b0;
    logic        req_nofl = 1'b0;
    logic [63:0] rd_data;
    logic        flush_pulse;
    logic        cfg_err;
    logic        priv_viol;
    logic [1:0]  tt_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench model of the register file
    logic [63:0] m_urp, m_srp, m_rd;
    logic [31:0] m_tc, m_tt0, m_tt1;
    logic [15:0] m_sr;
    bit          pend_err;
    string       pend_tag;

    always #2 clk = ~clk;

    mmu_ctl_regs u_mmu_ctl_regs (
        .clk, .rst_n, .req_valid, .req_write, .req_sel, .req_wdata,
        .req_super, .req_nofl, .rd_data, .flush_pulse, .cfg_err, .priv_viol, .tt_en
    );

    function automatic bit b_tc_ok(logic [31:0] t);
        int  total;
        bit  stop;
        total = int'(t[23:20]) + int'(t[19:16]);
        stop  = 0;
        for (int k = 3; k >= 0; k--) begin
            if (t[k*4 +: 4] == 4'd0) stop = 1;
            if (!stop) total += int'(t[k*4 +: 4]);
        end
        return (t[23:20] >= 4'd8) && (total == 32);
    endfunction

    function automatic logic [63:0] b_read(logic [2:0] s);
        case (s)
            3'd0: return m_urp;
            3'd1: return m_srp;
            3'd2: return {32'd0, m_tc};
            3'd3: return {32'd0, m_tt0};
            3'd4: return {32'd0, m_tt1};
            3'd5: return {48'd0, m_sr};
            default: return 64'd0;
        endcase
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(bit v, bit w, logic [2:0] s, logic [63:0] d, bit sup, bit nofl, string tag);
        bit    e_flush, e_priv, new_err;
        string f_tag, e_tag;
        @(negedge clk);
        req_valid = v; req_write = w; req_sel = s; req_wdata = d;
        req_super = sup; req_nofl = nofl;
        @(posedge clk);
        e_flush = v && sup && w && (s <= 3'd4) && !nofl;
        e_priv  = v && !sup;
        new_err = v && sup && w && (((s <= 3'd1) && (d[33:32] == 2'b00)) ||
                                    ((s == 3'd2) && d[31] && !b_tc_ok(d[31:0])));
        e_tag   = (s <= 3'd1) ? "R6" : "R7";
        if (v && sup && w && s == 3'd5) f_tag = "R5";
        else if (nofl)                  f_tag = "R4";
        else                            f_tag = "R3";
        if (v && sup && w) begin
            case (s)
                3'd0: m_urp = d;
                3'd1: m_srp = d;
                3'd2: m_tc  = (d[31] && b_tc_ok(d[31:0])) ? {1'b0, d[30:0]} : d[31:0];
                3'd3: m_tt0 = d[31:0];
                3'd4: m_tt1 = d[31:0];
                3'd5: m_sr  = d[15:0];
                default: ;
            endcase
        end
        if (v && sup && !w) m_rd = b_read(s);
        #1;
        chk(f_tag, "flush_pulse", 64'(flush_pulse), 64'(e_flush));
        chk("R10", "priv_viol", 64'(priv_viol), 64'(e_priv));
        chk(pend_tag, "cfg_err", 64'(cfg_err), 64'(pend_err));
        chk(tag, "rd_data", rd_data, m_rd);
        chk("R9", "tt_en", 64'(tt_en), 64'({m_tt1[15], m_tt0[15]}));
        pend_err = new_err;
        pend_tag = e_tag;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        m_urp = '0; m_srp = '0; m_rd = '0; m_tc = '0; m_tt0 = '0; m_tt1 = '0; m_sr = '0;
        pend_err = 0; pend_tag = "R7";
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs quiet during reset
        chk("R1", "flush in reset", 64'(flush_pulse), 64'd0);
        chk("R1", "rd_data in reset", rd_data, 64'd0);
        chk("R1", "tt_en in reset", 64'(tt_en), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < 6; s++) step(1, 0, 3'(s), 64'd0, 1, 0, "R1");

        // R2, R3: full-width root pointer
        step(1, 1, 3'd0, 64'h1234_5672_89AB_CDEF, 1, 0, "R3");
        step(1, 0, 3'd0, 64'd0, 1, 0, "R2");
        // R6: bad descriptor stored, error one cycle after visibility
        step(1, 1, 3'd1, 64'h0000_0010_0000_0040, 1, 0, "R6");
        step(1, 0, 3'd1, 64'd0, 1, 0, "R6");
        step(0, 0, 3'd0, 64'd0, 1, 0, "R6");
        // R8: enable clear, no check; R2 truncation
        step(1, 1, 3'd2, 64'hFFFF_FFFF_0012_3456, 1, 0, "R8");
        step(1, 0, 3'd2, 64'd0, 1, 0, "R2");
        // R8: passing check clears enable bit
        step(1, 1, 3'd2, 64'h0000_0000_80C0_AA00, 1, 0, "R8");
        step(1, 0, 3'd2, 64'd0, 1, 0, "R8");
        // R8: index sum stops at first zero field
        step(1, 1, 3'd2, 64'h0000_0000_80C0_AA05, 1, 0, "R8");
        step(1, 0, 3'd2, 64'd0, 1, 0, "R8");
        // R7: page size below minimum
        step(1, 1, 3'd2, 64'h0000_0000_8071_CC00, 1, 0, "R7");
        step(1, 0, 3'd2, 64'd0, 1, 0, "R7");
        // R7: sum of 31
        step(1, 1, 3'd2, 64'h0000_0000_80C0_A900, 1, 0, "R7");
        step(1, 0, 3'd2, 64'd0, 1, 0, "R7");
        // R9 and R4
        step(1, 1, 3'd3, 64'h0000_0000_0000_8001, 1, 0, "R9");
        step(1, 1, 3'd4, 64'h0000_0000_1234_8000, 1, 1, "R4");
        step(1, 1, 3'd3, 64'h0000_0000_FFFF_7FFF, 1, 0, "R9");
        step(1, 0, 3'd4, 64'd0, 1, 0, "R9");
        // R5: status write never flushes; 16-bit store
        step(1, 1, 3'd5, 64'hFFFF_FFFF_FFFF_A5C3, 1, 0, "R5");
        step(1, 0, 3'd5, 64'd0, 1, 0, "R5");
        // R10: user-state write and read rejected
        step(1, 1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R10");
        step(1, 0, 3'd2, 64'd0, 0, 0, "R10");
        step(1, 0, 3'd0, 64'd0, 1, 0, "R10");
        // R12: unmapped selects
        step(1, 1, 3'd6, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, "R12");
        step(1, 0, 3'd7, 64'd0, 1, 0, "R12");
        for (int s = 0; s < 6; s++) step(1, 0, 3'(s), 64'd0, 1, 0, "R12");
        // R11: reads repeat, rd_data holds over idle cycles
        step(1, 0, 3'd2, 64'd0, 1, 0, "R11");
        step(1, 0, 3'd2, 64'd0, 1, 0, "R11");
        step(0, 1, 3'd2, 64'd0, 1, 0, "R11");
        step(0, 0, 3'd0, 64'd0, 1, 0, "R11");
        // error of one write beside flush of the next
        step(1, 1, 3'd0, 64'h0000_0000_0000_0000, 1, 0, "R6");
        step(1, 1, 3'd3, 64'h0000_0000_0000_0000, 1, 0, "R3");
        step(1, 1, 3'd4, 64'h0000_0000_0000_0000, 0, 0, "R10");

        // constrained random traffic
        for (int n = 0; n < 3000; n++) begin
            bit          v, w, sup, nofl;
            logic [2:0]  s;
            logic [63:0] d;
            v    = ($urandom % 8) != 0;
            w    = ($urandom % 2) != 0;
            s    = 3'($urandom % 8);
            sup  = ($urandom % 8) != 0;
            nofl = ($urandom % 4) == 0;
            d    = {$urandom, $urandom};
            if (s == 3'd2 && ($urandom % 3) == 0) begin
                int ps;
                ps = 8 + int'($urandom % 5);
                d[31:0] = {1'b1, 7'd0, 4'(ps), 4'd0, 4'd12, 4'(32 - ps - 12), 4'd0, 4'($urandom % 16)};
            end
            step(v, w, s, d, sup, nofl, "R2");
        end
        step(0, 0, 3'd0, 64'd0, 1, 0, "R2");
        step(0, 0, 3'd0, 64'd0, 1, 0, "R2");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule